// File: doc/BRIEF.md
# Dual-Channel Simultaneous-Sampling ADC Readout Controller

This block sits on the host side of a converter that samples two channels at the same instant and returns both results over two serial data lines. A single-cycle start request makes the controller drive its active-low conversion-start output low for a fixed number of system clocks. It then waits for the converter's busy signal to fall. Only after that fall does it run a serial clock and shift both results in together. The serial clock comes from the system clock through an even divider.

When both words are complete, the controller widens each word to 16 bits. It sign-extends the word for the bipolar ranges and zero-extends it for the unipolar range. It then presents both words with a one-cycle valid strobe. If busy never falls, a timeout returns the controller to idle and raises a one-cycle error pulse.

The controller also drives two static outputs:
- a 2-bit range-select code, taken from a configuration input only while idle;
- a reference-select level, fixed from reset.

Top module: `dual_sar_reader`

## Requirements
- R1: Each accepted start request drives `cnv_n_o` low for exactly `CONV_LOW_CYC` system clocks, once.
- R2: `sclk_o` is low whenever `busy_i` is high, and it idles low outside a readout.
- R3: After `busy_i` falls in the waiting phase, exactly `RES_W` serial clock pulses are issued. Each pulse is high for `SCLK_DIV/2` system clocks.
- R4: Both data lines are sampled on the same rising `sclk_o` edges, most significant bit first.
- R5: `valid_o` is a one-cycle pulse after the last bit. `data_a_o` and `data_b_o` hold their values until the next completed readout.
- R6: For range codes 00 (±10 V) and 01 (±5 V), each result is two's complement, sign-extended to 16 bits.
- R7: For range code 10 (0 to 10 V), each result is zero-extended to 16 bits.
- R8: `range_o` takes `range_cfg_i` only while idle. Code 11 is reserved and is ignored. `range_o` is stable outside idle and resets to 00.
- R9: `ref_sel_o` equals `REF_INTERNAL` from reset (1 = internal reference, 0 = external).
- R10: If `busy_i` has not fallen within `BUSY_TIMEOUT` clocks after `cnv_n_o` returns high, `err_o` pulses for one cycle, no `valid_o` is produced, and the controller returns to idle.
- R11: A start request outside idle is ignored: it produces no extra `cnv_n_o` pulse.
- R12: A fall of `busy_i` while idle has no effect: no serial clock and no `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled in idle |
| range_cfg_i | input | 2 | Requested range code |
| busy_i | input | 1 | Converter busy handshake |
| sdo_a_i | input | 1 | Serial data, channel A |
| sdo_b_i | input | 1 | Serial data, channel B |
| cnv_n_o | output | 1 | Active-low conversion start |
| sclk_o | output | 1 | Serial clock to converter |
| range_o | output | 2 | Static range select |
| ref_sel_o | output | 1 | Reference select, 1 = internal |
| data_a_o | output | 16 | Widened result, channel A |
| data_b_o | output | 16 | Widened result, channel B |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | One-cycle busy-timeout pulse |

## Verification
The bound checker watches several properties on every cycle:
- the width of the start pulse;
- the absence of a serial clock while busy is high, and before busy has fallen;
- the pulse count at each strobe and the single-cycle shape of the strobe;
- the upper bits of both words against the current range;
- the stability of `range_o` outside idle;
- the separation of error and valid;
- that start pulses begin only from idle.

Only the bench scenarios can show the rest:
- that the captured words match what a converter model sent, bit for bit and MSB first;
- the exact timeout distance;
- that a reserved range code is ignored;
- that stray start requests and stray busy falls leave the ports quiet.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } dsr_state_e;

  localparam int unsigned OUT_W = 16;

  localparam logic [1:0] RNG_BIP10 = 2'b00;
  localparam logic [1:0] RNG_BIP5  = 2'b01;
  localparam logic [1:0] RNG_UNI10 = 2'b10;
  localparam logic [1:0] RNG_RSVD  = 2'b11;

  // True when the range code selects the unipolar input span.
  function automatic logic is_unipolar(input logic [1:0] rng);
    return rng == RNG_UNI10;
  endfunction

  // A reserved code must never reach the range output.
  function automatic logic range_legal(input logic [1:0] rng);
    return rng != RNG_RSVD;
  endfunction

  // Fill the bits above the result width with the sign bit (bipolar) or zeros (unipolar).
  function automatic logic [OUT_W-1:0] widen(input logic [OUT_W-1:0] raw,
                                             input int unsigned w,
                                             input logic uni);
    logic [OUT_W-1:0] r;
    logic             s;
    s = raw[w-1];
    for (int i = 0; i < OUT_W; i++) begin
      r[i] = (i < int'(w)) ? raw[i] : (uni ? 1'b0 : s);
    end
    return r;
  endfunction

endpackage

// File: rtl/dsr_sclk_gen.sv
module dsr_sclk_gen #(
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = SCLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap_w;

  assign wrap_w = (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap_w) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q & en_i;
  assign rise_o = en_i & wrap_w & ~sclk_q;
  assign fall_o = en_i & wrap_w & sclk_q;

endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  // Shift left with new bits entering at the LSB: the first bit sampled ends up as the MSB.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
    end else if (shift_i) begin
      sh_q <= {sh_q[W-2:0], din_i};
    end
  end

  assign word_o = sh_q;

endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
#(
  parameter int unsigned RES_W        = 12,
  parameter int unsigned CONV_LOW_CYC = 3,
  parameter int unsigned BUSY_TIMEOUT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  output logic cnv_n_o,
  output logic shift_en_o,
  output logic clr_o,
  output logic load_o,
  output logic err_o,
  output logic idle_o,
  output logic busy_fall_o
);
  localparam int unsigned CMAX  = (CONV_LOW_CYC > BUSY_TIMEOUT) ? CONV_LOW_CYC : BUSY_TIMEOUT;
  localparam int unsigned CNT_W = $clog2(CMAX + 1);
  localparam int unsigned BIT_W = $clog2(RES_W + 1);

  dsr_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bits_q;
  logic             busy_q;
  logic             err_q;
  logic             conv_end_w;
  logic             tmo_w;
  logic             last_fall_w;

  assign busy_fall_o = busy_q & ~busy_i;
  assign conv_end_w  = (st_q == ST_CONV) && (cnt_q == CNT_W'(CONV_LOW_CYC - 1));
  assign tmo_w       = (st_q == ST_WAIT) && !busy_fall_o && (cnt_q == CNT_W'(BUSY_TIMEOUT - 1));
  assign last_fall_w = (st_q == ST_SHIFT) && sclk_fall_i && (bits_q == BIT_W'(RES_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      bits_q <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_i;
      err_q  <= tmo_w;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) st_q <= ST_CONV;
        end
        ST_CONV: begin
          if (conv_end_w) begin
            cnt_q <= '0;
            st_q  <= ST_WAIT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (busy_fall_o) begin
            bits_q <= '0;
            st_q   <= ST_SHIFT;
          end else if (tmo_w) begin
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (sclk_rise_i) bits_q <= bits_q + 1'b1;
          if (last_fall_w) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cnv_n_o    = (st_q != ST_CONV);
  assign shift_en_o = (st_q == ST_SHIFT);
  assign clr_o      = (st_q == ST_IDLE) && start_i;
  assign load_o     = (st_q == ST_DONE);
  assign err_o      = err_q;
  assign idle_o     = (st_q == ST_IDLE);

endmodule

// File: rtl/dual_sar_reader.sv
module dual_sar_reader
  import dsr_pkg::*;
#(
  parameter int unsigned RES_W        = 12,
  parameter int unsigned SCLK_DIV     = 4,
  parameter int unsigned CONV_LOW_CYC = 3,
  parameter int unsigned BUSY_TIMEOUT = 256,
  parameter bit          REF_INTERNAL = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  range_cfg_i,
  input  logic        busy_i,
  input  logic        sdo_a_i,
  input  logic        sdo_b_i,
  output logic        cnv_n_o,
  output logic        sclk_o,
  output logic [1:0]  range_o,
  output logic        ref_sel_o,
  output logic [15:0] data_a_o,
  output logic [15:0] data_b_o,
  output logic        valid_o,
  output logic        err_o
);
  localparam int unsigned NCH = 2;
  localparam int unsigned PAD = OUT_W - RES_W;

  // Internal events, named for the bound checker.
  logic idle_w;
  logic busy_fall_w;
  logic sclk_rise_w;
  logic sclk_fall_w;
  logic shift_en_w;
  logic clr_w;
  logic load_w;

  logic [NCH-1:0]   sdo_w;
  logic [RES_W-1:0] word_w  [NCH];
  logic [OUT_W-1:0] data_q  [NCH];
  logic             valid_q;
  logic [1:0]       range_q;
  logic             ref_q;

  assign sdo_w = {sdo_b_i, sdo_a_i};

  dsr_ctrl #(
    .RES_W       (RES_W),
    .CONV_LOW_CYC(CONV_LOW_CYC),
    .BUSY_TIMEOUT(BUSY_TIMEOUT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_i     (busy_i),
    .sclk_rise_i(sclk_rise_w),
    .sclk_fall_i(sclk_fall_w),
    .cnv_n_o    (cnv_n_o),
    .shift_en_o (shift_en_w),
    .clr_o      (clr_w),
    .load_o     (load_w),
    .err_o      (err_o),
    .idle_o     (idle_w),
    .busy_fall_o(busy_fall_w)
  );

  dsr_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (shift_en_w),
    .sclk_o(sclk_o),
    .rise_o(sclk_rise_w),
    .fall_o(sclk_fall_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    dsr_shifter #(.W(RES_W)) u_sh (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr_w),
      .shift_i(sclk_rise_w),
      .din_i  (sdo_w[ch]),
      .word_o (word_w[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[ch] <= '0;
      end else if (load_w) begin
        data_q[ch] <= widen({{PAD{1'b0}}, word_w[ch]}, RES_W, is_unipolar(range_q));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      range_q <= RNG_BIP10;
      ref_q   <= REF_INTERNAL;
    end else begin
      valid_q <= load_w;
      if (idle_w && range_legal(range_cfg_i)) range_q <= range_cfg_i;
    end
  end

  assign valid_o   = valid_q;
  assign data_a_o  = data_q[0];
  assign data_b_o  = data_q[1];
  assign range_o   = range_q;
  assign ref_sel_o = ref_q;

endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int unsigned RES_W        = 12,
  parameter int unsigned CONV_LOW_CYC = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cnv_n_o,
  input logic        sclk_o,
  input logic        busy_i,
  input logic        valid_o,
  input logic        err_o,
  input logic [1:0]  range_o,
  input logic [15:0] data_a_o,
  input logic [15:0] data_b_o,
  input logic        idle_w,
  input logic        busy_fall_w
);
  localparam int unsigned PAD = 16 - RES_W;

  int   low_cnt;
  int   rise_cnt;
  logic sclk_prev;
  logic fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= 0;
      rise_cnt  <= 0;
      sclk_prev <= 1'b0;
      fall_seen <= 1'b0;
    end else begin
      low_cnt   <= cnv_n_o ? 0 : low_cnt + 1;
      sclk_prev <= sclk_o;
      if (!cnv_n_o) rise_cnt <= 0;
      else if (sclk_o && !sclk_prev) rise_cnt <= rise_cnt + 1;
      if (!cnv_n_o) fall_seen <= 1'b0;
      else if (busy_fall_w && !idle_w) fall_seen <= 1'b1;
    end
  end

  p_cnv_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_n_o) |-> low_cnt == int'(CONV_LOW_CYC));

  p_quiet_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !sclk_o);

  p_sclk_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> fall_seen);

  p_pulse_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rise_cnt == int'(RES_W));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && range_o != 2'b10) |->
      (data_a_o[15:RES_W] == {PAD{data_a_o[RES_W-1]}}) &&
      (data_b_o[15:RES_W] == {PAD{data_b_o[RES_W-1]}}));

  p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && range_o == 2'b10) |->
      (data_a_o[15:RES_W] == '0) && (data_b_o[15:RES_W] == '0));

  p_range_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w |=> $stable(range_o));

  p_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o && cnv_n_o && idle_w);

  p_start_from_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_n_o) |-> $past(idle_w));

endmodule

bind dual_sar_reader dsr_checker #(
  .RES_W       (RES_W),
  .CONV_LOW_CYC(CONV_LOW_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnv_n_o    (cnv_n_o),
  .sclk_o     (sclk_o),
  .busy_i     (busy_i),
  .valid_o    (valid_o),
  .err_o      (err_o),
  .range_o    (range_o),
  .data_a_o   (data_a_o),
  .data_b_o   (data_b_o),
  .idle_w     (idle_w),
  .busy_fall_w(busy_fall_w)
);

// File: tb/sim_dual_sar_reader.sv
`timescale 1ns/1ps
module sim_dual_sar_reader;
  localparam int RES_W = 12;
  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int LOWC  = 3;
  localparam int TMO   = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  range_cfg_i = 2'b00;
  logic        busy_r = 1'b0;
  logic        glitch_b = 1'b0;
  logic        busy_i;
  logic        sa = 1'b0, sb = 1'b0;
  logic        cnv_n_o, sclk_o, ref_sel_o, valid_o, err_o;
  logic [1:0]  range_o;
  logic [15:0] data_a_o, data_b_o;

  assign busy_i = busy_r | glitch_b;

  always #10 clk = ~clk;

  dual_sar_reader #(.RES_W(RES_W), .SCLK_DIV(DIV), .CONV_LOW_CYC(LOWC),
                    .BUSY_TIMEOUT(TMO), .REF_INTERNAL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .range_cfg_i(range_cfg_i),
    .busy_i(busy_i), .sdo_a_i(sa), .sdo_b_i(sb), .cnv_n_o(cnv_n_o),
    .sclk_o(sclk_o), .range_o(range_o), .ref_sel_o(ref_sel_o),
    .data_a_o(data_a_o), .data_b_o(data_b_o), .valid_o(valid_o), .err_o(err_o));

  int checks = 0;
  int errors = 0;

  // Converter model: busy rises after conversion start, falls later with the MSB on the lines.
  logic [RES_W-1:0] wa = '0, wb = '0;
  logic             stub_hang = 1'b0;
  int               idx = -1;

  always begin
    @(negedge cnv_n_o);
    repeat (2) @(negedge clk);
    busy_r = 1'b1;
    repeat (10) @(negedge clk);
    while (stub_hang) @(negedge clk);
    busy_r = 1'b0;
    sa = wa[RES_W-1];
    sb = wb[RES_W-1];
    idx = RES_W - 2;
  end

  always @(negedge sclk_o) begin
    if (idx >= 0) begin
      sa = wa[idx];
      sb = wb[idx];
      idx = idx - 1;
    end
  end

  // Port monitor with running totals.
  int   low_tot = 0, falls_tot = 0, rises_tot = 0, hi_bad = 0, busy_viol = 0, valid_tot = 0, hi_run = 0;
  logic pc = 1'b1, ps = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cnv_n_o) low_tot++;
      if (pc && !cnv_n_o) falls_tot++;
      if (!ps && sclk_o) rises_tot++;
      if (sclk_o) hi_run++;
      if (ps && !sclk_o) begin
        if (hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
      if (busy_i && sclk_o) busy_viol++;
      if (valid_o) valid_tot++;
    end
    pc = cnv_n_o;
    ps = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [RES_W-1:0] w, input logic [1:0] rng);
    int v;
    v = int'(w);
    if (rng != 2'b10 && v >= (1 << (RES_W - 1))) v = v - (1 << RES_W);
    return 16'(v);
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_end(output bit got_valid);
    got_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (valid_o) begin
        got_valid = 1'b1;
        break;
      end
      if (err_o) break;
    end
  endtask

  task automatic t_reset();
    chk(cnv_n_o == 1'b1, "R1 reset cnv_n", cnv_n_o, 1);
    chk(sclk_o == 1'b0, "R2 reset sclk", sclk_o, 0);
    chk(valid_o == 1'b0 && err_o == 1'b0, "R5 reset strobes", {valid_o, err_o}, 0);
    chk(range_o == 2'b00, "R8 reset range", range_o, 0);
    chk(ref_sel_o == 1'b1, "R9 ref select", ref_sel_o, 1);
  endtask

  task automatic t_conv(input logic [RES_W-1:0] a, input logic [RES_W-1:0] b, input logic [1:0] rng);
    int l0, f0, r0, hb0, bv0;
    bit gv;
    logic [15:0] ea, eb;
    range_cfg_i = rng;
    @(negedge clk);
    wa = a;
    wb = b;
    l0 = low_tot; f0 = falls_tot; r0 = rises_tot; hb0 = hi_bad; bv0 = busy_viol;
    pulse_start();
    wait_end(gv);
    ea = expect_word(a, rng);
    eb = expect_word(b, rng);
    chk(gv, "R5 valid seen", gv, 1);
    chk(low_tot - l0 == LOWC, "R1 cnv low width", low_tot - l0, LOWC);
    chk(falls_tot - f0 == 1, "R1 single cnv pulse", falls_tot - f0, 1);
    chk(busy_viol == bv0, "R2 sclk during busy", busy_viol - bv0, 0);
    chk(rises_tot - r0 == RES_W, "R3 pulse count", rises_tot - r0, RES_W);
    chk(hi_bad == hb0, "R3 sclk high width", hi_bad - hb0, 0);
    chk(data_a_o == ea, (rng == 2'b10) ? "R7 R4 channel A" : "R6 R4 channel A", data_a_o, ea);
    chk(data_b_o == eb, (rng == 2'b10) ? "R7 R4 channel B" : "R6 R4 channel B", data_b_o, eb);
    @(negedge clk);
    chk(valid_o == 1'b0, "R5 valid one cycle", valid_o, 0);
    repeat (5) @(negedge clk);
    chk(data_a_o == ea && data_b_o == eb, "R5 data held", data_a_o, ea);
  endtask

  task automatic t_range_rules();
    bit gv;
    range_cfg_i = 2'b01;
    repeat (2) @(negedge clk);
    range_cfg_i = 2'b11;
    repeat (3) @(negedge clk);
    chk(range_o == 2'b01, "R8 reserved code ignored", range_o, 1);
    range_cfg_i = 2'b01;
    @(negedge clk);
    wa = 12'hF00;
    wb = 12'h0F0;
    pulse_start();
    repeat (4) @(negedge clk);
    range_cfg_i = 2'b10;
    repeat (6) @(negedge clk);
    chk(range_o == 2'b01, "R8 range held mid-conversion", range_o, 1);
    wait_end(gv);
    chk(data_a_o == 16'hFF00, "R8 R6 format used held range", data_a_o, 16'hFF00);
    repeat (2) @(negedge clk);
    chk(range_o == 2'b10, "R8 range taken in idle", range_o, 2);
  endtask

  task automatic t_start_ignored();
    int f0;
    bit gv;
    range_cfg_i = 2'b00;
    wa = 12'h123;
    wb = 12'hABC;
    f0 = falls_tot;
    pulse_start();
    while (!sclk_o) @(negedge clk);
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    wait_end(gv);
    repeat (20) @(negedge clk);
    chk(falls_tot - f0 == 1, "R11 start outside idle ignored", falls_tot - f0, 1);
    chk(data_b_o == 16'hFABC, "R11 readout intact", data_b_o, 16'hFABC);
  endtask

  task automatic t_timeout();
    int n, v0;
    stub_hang = 1'b1;
    v0 = valid_tot;
    pulse_start();
    while (!cnv_n_o) @(negedge clk);
    n = 0;
    while (!err_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(err_o == 1'b1, "R10 error raised", err_o, 1);
    chk(n == TMO, "R10 timeout distance", n, TMO);
    @(negedge clk);
    chk(err_o == 1'b0, "R10 error one cycle", err_o, 0);
    stub_hang = 1'b0;
    repeat (30) @(negedge clk);
    chk(valid_tot == v0, "R10 R12 no data after timeout", valid_tot - v0, 0);
    chk(sclk_o == 1'b0 && cnv_n_o == 1'b1, "R12 quiet after late busy fall", {sclk_o, cnv_n_o}, 1);
  endtask

  task automatic t_idle_busy();
    int v0, r0;
    v0 = valid_tot;
    r0 = rises_tot;
    @(negedge clk);
    glitch_b = 1'b1;
    repeat (3) @(negedge clk);
    glitch_b = 1'b0;
    repeat (20) @(negedge clk);
    chk(valid_tot == v0 && rises_tot == r0, "R12 idle busy fall ignored", valid_tot - v0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv(12'h800, 12'h7FF, 2'b00);
    t_conv(12'hA5C, 12'h3C1, 2'b01);
    t_conv(12'hFFF, 12'h001, 2'b10);
    t_conv(12'h555, 12'hAAA, 2'b00);
    t_range_rules();
    t_start_ignored();
    t_timeout();
    t_idle_busy();
    t_conv(12'h9E7, 12'h000, 2'b10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule